// File: doc/BRIEF.md
# Control Endpoint Handshake Responder

This block answers the host on a USB function's control endpoint at packet level. A token decoder upstream hands it one pulse per decoded SETUP, IN or OUT token, together with the data PID and length of any data packet that followed. The host's handshake to packets the block sent comes back as an ACK pulse or a timeout pulse. In the cycle after each token the block states what the transmitter must send: ACK, NAK, a DATA0/DATA1 packet taken from the transmit buffer, or a zero-length DATA1 packet for a status stage.

Firmware works through a few pulses and levels. It marks the transmit buffer loaded, clears the transmit-complete flag, clears the receive flags, and enables the endpoint and its interrupt. The block tracks the setup, data and status stages of no-data, control-read and control-write transfers. It handles retries and the data toggle by itself and latches the transfer direction from the setup stage. Serial coding, CRC and the packet buffers sit outside this block.

Top module: `ctl_ep_responder`

## Requirements
- R1: After reset the stage is idle, `rsp_kind` is 0 (none), and `txrdy`, `txcmp`, `rx_setup`, `rx_out`, `xfer_dir` and `irq` are all 0.
- R2: While `ep_en` is low, tokens produce no response (`rsp_kind` 0) and change no flag or stage. A response is only ever produced in the cycle after an enabled token.
- R3: An enabled SETUP (`tok_kind` 0) is answered with ACK (`rsp_kind` 1) in the next cycle. It sets `rx_setup`, loads `xfer_dir` from `setup_dir` (1 = device to host), and restarts the toggle so that the first data packet is DATA1.
- R4: In a no-data transfer (`setup_nodata` high), each IN (`tok_kind` 1) is answered with zero-length DATA1 (`rsp_kind` 4, `rsp_zlp` 1), repeated after a timeout. The host ACK sets `txcmp` and returns the stage to idle, where IN gets NAK (`rsp_kind` 2).
- R5: In a control-read data stage, IN with `txrdy` low gets NAK. IN with `txrdy` high gets DATA1 for the first packet and the other PID after each acknowledged packet (DATA0 is `rsp_kind` 3). After a timeout the same PID is resent.
- R6: A host ACK to a packet the block sent clears `txrdy` and sets `txcmp` one cycle later.
- R7: In a control-read transfer, an OUT (`tok_kind` 2) carrying zero-length DATA1 gets NAK while `txcmp` is set. Once `txcmp` is clear it gets ACK and the stage returns to idle. Any other OUT in that stage gets NAK.
- R8: In a control-write data stage, OUT gets NAK while `rx_out` is set. Otherwise it gets ACK. If its PID matches the expected toggle it sets `rx_out` and flips the toggle. If the PID does not match, the packet is a duplicate: it is acknowledged but sets no flag.
- R9: In a control-write status stage, IN gets zero-length DATA1, repeated after a timeout. The host ACK sets `txcmp` and returns the stage to idle.
- R10: `irq` is high exactly when `fw_irq_en` is high and at least one of `txcmp`, `rx_setup`, `rx_out` is set.
- R11: A SETUP in the middle of a transfer abandons it and starts a new one; the first data packet is again DATA1.
- R12: A host ACK or timeout when no sent packet is outstanding changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ep_en | input | 1 | Endpoint enable from firmware |
| tok_valid | input | 1 | One-cycle pulse: a token was decoded |
| tok_kind | input | 2 | 0 SETUP, 1 IN, 2 OUT |
| rx_data1 | input | 1 | Data PID of the packet after SETUP/OUT: 1 = DATA1 |
| rx_len | input | LEN_W | Byte count of that data packet |
| setup_dir | input | 1 | Direction bit decoded from the setup packet |
| setup_nodata | input | 1 | Setup packet announces no data stage |
| hs_ack | input | 1 | Pulse: host acknowledged the last packet sent |
| hs_timeout | input | 1 | Pulse: no handshake came back from the host |
| fw_txrdy_set | input | 1 | Pulse: firmware loaded the transmit buffer |
| fw_txcmp_clr | input | 1 | Pulse: firmware clears transmit-complete |
| fw_rx_clr | input | 1 | Pulse: firmware clears both receive flags |
| fw_irq_en | input | 1 | Interrupt enable |
| rsp_kind | output | 3 | Response: 0 none, 1 ACK, 2 NAK, 3 DATA0, 4 DATA1 |
| rsp_zlp | output | 1 | The data response is zero length |
| txrdy | output | 1 | Transmit buffer loaded and not yet acknowledged |
| txcmp | output | 1 | Transmit-complete flag |
| rx_setup | output | 1 | Setup packet received |
| rx_out | output | 1 | OUT data packet received |
| xfer_dir | output | 1 | Transfer direction latched at setup |
| irq | output | 1 | Interrupt request |

## Verification
The bench tests the status stages with a lost handshake. A design that advanced on the timeout would end the transfer early. A design that flipped the toggle on retry would send DATA0 where DATA1 is due. The bench also replays a control-write OUT with a stale PID. A design that ignored the toggle would raise `rx_out` twice for one packet.

For the control-read status OUT, the bench checks both the NAK while `txcmp` is set and the NAK for the wrong PID; a design that acknowledged early would let the host finish before firmware saw completion. Stray host ACKs in idle and a SETUP mid-transfer are also driven. A design that touched flags on them, or kept the old toggle, shows a wrong flag or a wrong PID at the ports.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;

    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_IN    = 2'd1,
        TK_OUT   = 2'd2
    } tok_e;

    typedef enum logic [2:0] {
        RS_NONE  = 3'd0,
        RS_ACK   = 3'd1,
        RS_NAK   = 3'd2,
        RS_DATA0 = 3'd3,
        RS_DATA1 = 3'd4
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_NODATA = 2'd1,
        ST_RD     = 2'd2,
        ST_WR     = 2'd3
    } stage_e;

    typedef struct packed {
        stage_e st;
        logic   tgl;       // PID expected / to send next: 1 = DATA1
        logic   wait_ack;  // a sent packet awaits the host handshake
        logic   dir;
        rsp_e   rsp;
        logic   zlp;
    } fsm_s;

    typedef struct packed {
        logic txrdy;
        logic txcmp;
        logic rx_setup;
        logic rx_out;
    } flags_s;

    localparam fsm_s FSM_RST = '{st: ST_IDLE, tgl: 1'b0, wait_ack: 1'b0,
                                 dir: 1'b0, rsp: RS_NONE, zlp: 1'b0};
    localparam flags_s FLAGS_RST = '{txrdy: 1'b0, txcmp: 1'b0,
                                     rx_setup: 1'b0, rx_out: 1'b0};

endpackage

// File: rtl/ctl_ep_stage_fsm.sv
module ctl_ep_stage_fsm
    import ctl_ep_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ep_en,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             rx_data1,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             setup_dir,
    input  logic             setup_nodata,
    input  logic             hs_ack,
    input  logic             hs_timeout,
    input  logic             txrdy,
    input  logic             txcmp,
    input  logic             rx_out,
    output logic [2:0]       rsp_kind,
    output logic             rsp_zlp,
    output logic             dir,
    output logic             ev_setup,
    output logic             ev_tx_ack,
    output logic             ev_rx_data
);

    fsm_s q, d;
    logic zero_len;

    always_comb begin
        d          = q;
        d.rsp      = RS_NONE;
        d.zlp      = 1'b0;
        ev_setup   = 1'b0;
        ev_tx_ack  = 1'b0;
        ev_rx_data = 1'b0;
        zero_len   = (rx_len == '0);

        // handshake on the packet sent last
        if (hs_ack && q.wait_ack) begin
            d.wait_ack = 1'b0;
            ev_tx_ack  = 1'b1;
            if (q.st == ST_RD) d.tgl = ~q.tgl;
            else               d.st  = ST_IDLE;   // status stage done
        end else if (hs_timeout) begin
            d.wait_ack = 1'b0;                    // retry keeps the toggle
        end

        if (tok_valid && ep_en) begin
            case (tok_kind)
                TK_SETUP: begin
                    d.st       = setup_nodata ? ST_NODATA : (setup_dir ? ST_RD : ST_WR);
                    d.tgl      = 1'b1;
                    d.wait_ack = 1'b0;
                    d.dir      = setup_dir;
                    d.rsp      = RS_ACK;
                    ev_setup   = 1'b1;
                end
                TK_IN: begin
                    case (q.st)
                        ST_NODATA, ST_WR: begin
                            d.rsp      = RS_DATA1;
                            d.zlp      = 1'b1;
                            d.wait_ack = 1'b1;
                        end
                        ST_RD: begin
                            if (txrdy) begin
                                d.rsp      = q.tgl ? RS_DATA1 : RS_DATA0;
                                d.wait_ack = 1'b1;
                            end else begin
                                d.rsp = RS_NAK;
                            end
                        end
                        default: d.rsp = RS_NAK;
                    endcase
                end
                TK_OUT: begin
                    case (q.st)
                        ST_RD: begin
                            if (rx_data1 && zero_len && !txcmp) begin
                                d.rsp = RS_ACK;
                                d.st  = ST_IDLE;
                            end else begin
                                d.rsp = RS_NAK;
                            end
                        end
                        ST_WR: begin
                            if (rx_out) begin
                                d.rsp = RS_NAK;
                            end else begin
                                d.rsp = RS_ACK;
                                if (rx_data1 == q.tgl) begin
                                    d.tgl      = ~q.tgl;
                                    ev_rx_data = 1'b1;
                                end
                            end
                        end
                        default: d.rsp = RS_NAK;
                    endcase
                end
                default: d.rsp = RS_NONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= FSM_RST;
        else        q <= d;
    end

    assign rsp_kind = q.rsp;
    assign rsp_zlp  = q.zlp;
    assign dir      = q.dir;

endmodule

// File: rtl/ctl_ep_flags.sv
module ctl_ep_flags
    import ctl_ep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_setup,
    input  logic ev_tx_ack,
    input  logic ev_rx_data,
    input  logic fw_txrdy_set,
    input  logic fw_txcmp_clr,
    input  logic fw_rx_clr,
    input  logic fw_irq_en,
    output logic txrdy,
    output logic txcmp,
    output logic rx_setup,
    output logic rx_out,
    output logic irq
);

    flags_s q, d;

    // hardware events win over firmware clears in the same cycle;
    // a firmware load wins over the ACK clear of the previous packet
    always_comb begin
        d = q;
        if (ev_tx_ack) begin
            d.txrdy = 1'b0;
            d.txcmp = 1'b1;
        end
        if (fw_txrdy_set)              d.txrdy = 1'b1;
        if (fw_txcmp_clr && !ev_tx_ack) d.txcmp = 1'b0;
        if (fw_rx_clr) begin
            d.rx_setup = 1'b0;
            d.rx_out   = 1'b0;
        end
        if (ev_setup)   d.rx_setup = 1'b1;
        if (ev_rx_data) d.rx_out   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= FLAGS_RST;
        else        q <= d;
    end

    assign txrdy    = q.txrdy;
    assign txcmp    = q.txcmp;
    assign rx_setup = q.rx_setup;
    assign rx_out   = q.rx_out;
    assign irq      = fw_irq_en & (q.txcmp | q.rx_setup | q.rx_out);

endmodule

// File: rtl/ctl_ep_responder.sv
module ctl_ep_responder
    import ctl_ep_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ep_en,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             rx_data1,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             setup_dir,
    input  logic             setup_nodata,
    input  logic             hs_ack,
    input  logic             hs_timeout,
    input  logic             fw_txrdy_set,
    input  logic             fw_txcmp_clr,
    input  logic             fw_rx_clr,
    input  logic             fw_irq_en,
    output logic [2:0]       rsp_kind,
    output logic             rsp_zlp,
    output logic             txrdy,
    output logic             txcmp,
    output logic             rx_setup,
    output logic             rx_out,
    output logic             xfer_dir,
    output logic             irq
);

    logic ev_setup, ev_tx_ack, ev_rx_data;

    ctl_ep_stage_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ep_en        (ep_en),
        .tok_valid    (tok_valid),
        .tok_kind     (tok_kind),
        .rx_data1     (rx_data1),
        .rx_len       (rx_len),
        .setup_dir    (setup_dir),
        .setup_nodata (setup_nodata),
        .hs_ack       (hs_ack),
        .hs_timeout   (hs_timeout),
        .txrdy        (txrdy),
        .txcmp        (txcmp),
        .rx_out       (rx_out),
        .rsp_kind     (rsp_kind),
        .rsp_zlp      (rsp_zlp),
        .dir          (xfer_dir),
        .ev_setup     (ev_setup),
        .ev_tx_ack    (ev_tx_ack),
        .ev_rx_data   (ev_rx_data)
    );

    ctl_ep_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_setup     (ev_setup),
        .ev_tx_ack    (ev_tx_ack),
        .ev_rx_data   (ev_rx_data),
        .fw_txrdy_set (fw_txrdy_set),
        .fw_txcmp_clr (fw_txcmp_clr),
        .fw_rx_clr    (fw_rx_clr),
        .fw_irq_en    (fw_irq_en),
        .txrdy        (txrdy),
        .txcmp        (txcmp),
        .rx_setup     (rx_setup),
        .rx_out       (rx_out),
        .irq          (irq)
    );

endmodule

// File: rtl/ctl_ep_checker.sv
module ctl_ep_checker
    import ctl_ep_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ep_en,
    input logic       tok_valid,
    input logic [1:0] tok_kind,
    input logic       hs_ack,
    input logic       fw_irq_en,
    input logic [2:0] rsp_kind,
    input logic       rsp_zlp,
    input logic       txrdy,
    input logic       rx_setup,
    input logic       rx_out,
    input logic       irq
);

    assert_disabled_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !ep_en) |=> (rsp_kind == RS_NONE));

    assert_rsp_needs_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_kind != RS_NONE) |-> $past(tok_valid && ep_en));

    assert_setup_acked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && ep_en && tok_kind == TK_SETUP) |=> (rsp_kind == RS_ACK && rx_setup));

    assert_zlp_is_data1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_zlp |-> (rsp_kind == RS_DATA1));

    assert_txrdy_fall_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txrdy) |-> $past(hs_ack));

    assert_rxout_from_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_out) |-> $past(tok_valid && ep_en && tok_kind == TK_OUT));

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fw_irq_en);

endmodule

bind ctl_ep_responder ctl_ep_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ep_en     (ep_en),
    .tok_valid (tok_valid),
    .tok_kind  (tok_kind),
    .hs_ack    (hs_ack),
    .fw_irq_en (fw_irq_en),
    .rsp_kind  (rsp_kind),
    .rsp_zlp   (rsp_zlp),
    .txrdy     (txrdy),
    .rx_setup  (rx_setup),
    .rx_out    (rx_out),
    .irq       (irq)
);

// File: tb/ctl_ep_responder_tb_top.sv
module ctl_ep_responder_tb_top;

    localparam int LEN_W = 7;
    localparam int HALF  = 4;  // 8 ns period, 125 MHz

    localparam logic [2:0] OP_TOK = 3'd0, OP_ACK = 3'd1, OP_TMO = 3'd2,
                           OP_RDY = 3'd3, OP_CCLR = 3'd4, OP_RCLR = 3'd5;
    localparam logic [1:0] K_SU = 2'd0, K_IN = 2'd1, K_OUT = 2'd2;
    localparam logic [2:0] E_NONE = 3'd0, E_ACK = 3'd1, E_NAK = 3'd2,
                           E_D0 = 3'd3, E_D1 = 3'd4;

    // vector: op[12:10] tok[9:8] pid1[7] zerolen[6] dir[5] nodata[4] exp_rsp[3:1] exp_zlp[0]
    localparam int NV = 15;
    localparam logic [12:0] VEC [NV] = '{
        {OP_TOK,  K_SU,  1'b0, 1'b0, 1'b1, 1'b0, E_ACK,  1'b0}, // R3 setup, control read
        {OP_RCLR, K_SU,  1'b0, 1'b0, 1'b0, 1'b0, E_NONE, 1'b0},
        {OP_TOK,  K_IN,  1'b0, 1'b0, 1'b0, 1'b0, E_NAK,  1'b0}, // R5 buffer empty
        {OP_RDY,  K_SU,  1'b0, 1'b0, 1'b0, 1'b0, E_NONE, 1'b0},
        {OP_TOK,  K_IN,  1'b0, 1'b0, 1'b0, 1'b0, E_D1,   1'b0}, // R5 first packet DATA1
        {OP_TMO,  K_SU,  1'b0, 1'b0, 1'b0, 1'b0, E_NONE, 1'b0},
        {OP_TOK,  K_IN,  1'b0, 1'b0, 1'b0, 1'b0, E_D1,   1'b0}, // R5 retry same PID
        {OP_ACK,  K_SU,  1'b0, 1'b0, 1'b0, 1'b0, E_NONE, 1'b0},
        {OP_RDY,  K_SU,  1'b0, 1'b0, 1'b0, 1'b0, E_NONE, 1'b0},
        {OP_TOK,  K_IN,  1'b0, 1'b0, 1'b0, 1'b0, E_D0,   1'b0}, // R5 toggled
        {OP_ACK,  K_SU,  1'b0, 1'b0, 1'b0, 1'b0, E_NONE, 1'b0},
        {OP_TOK,  K_OUT, 1'b1, 1'b1, 1'b0, 1'b0, E_NAK,  1'b0}, // R7 txcmp still set
        {OP_CCLR, K_SU,  1'b0, 1'b0, 1'b0, 1'b0, E_NONE, 1'b0},
        {OP_TOK,  K_OUT, 1'b1, 1'b1, 1'b0, 1'b0, E_ACK,  1'b0}, // R7 status accepted
        {OP_TOK,  K_IN,  1'b0, 1'b0, 1'b0, 1'b0, E_NAK,  1'b0}  // R7 back in idle
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ep_en = 1'b1;
    logic             tok_valid = 1'b0;
    logic [1:0]       tok_kind = 2'd0;
    logic             rx_data1 = 1'b0;
    logic [LEN_W-1:0] rx_len = '0;
    logic             setup_dir = 1'b0;
    logic             setup_nodata = 1'b0;
    logic             hs_ack = 1'b0;
    logic             hs_timeout = 1'b0;
    logic             fw_txrdy_set = 1'b0;
    logic             fw_txcmp_clr = 1'b0;
    logic             fw_rx_clr = 1'b0;
    logic             fw_irq_en = 1'b0;
    logic [2:0]       rsp_kind;
    logic             rsp_zlp, txrdy, txcmp, rx_setup, rx_out, xfer_dir, irq;

    int n_chk = 0;
    int n_err = 0;

    always #HALF clk = ~clk;

    ctl_ep_responder #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ep_en(ep_en), .tok_valid(tok_valid),
        .tok_kind(tok_kind), .rx_data1(rx_data1), .rx_len(rx_len),
        .setup_dir(setup_dir), .setup_nodata(setup_nodata), .hs_ack(hs_ack),
        .hs_timeout(hs_timeout), .fw_txrdy_set(fw_txrdy_set),
        .fw_txcmp_clr(fw_txcmp_clr), .fw_rx_clr(fw_rx_clr), .fw_irq_en(fw_irq_en),
        .rsp_kind(rsp_kind), .rsp_zlp(rsp_zlp), .txrdy(txrdy), .txcmp(txcmp),
        .rx_setup(rx_setup), .rx_out(rx_out), .xfer_dir(xfer_dir), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive one op for one cycle; returns at the negedge after the capturing posedge
    task automatic apply(input logic [2:0] op, input logic [1:0] tk, input logic p1,
                         input logic zl, input logic dr, input logic nd);
        @(negedge clk);
        tok_valid    = (op == OP_TOK);
        tok_kind     = tk;
        rx_data1     = p1;
        rx_len       = zl ? 7'd0 : 7'd8;
        setup_dir    = dr;
        setup_nodata = nd;
        hs_ack       = (op == OP_ACK);
        hs_timeout   = (op == OP_TMO);
        fw_txrdy_set = (op == OP_RDY);
        fw_txcmp_clr = (op == OP_CCLR);
        fw_rx_clr    = (op == OP_RCLR);
        @(negedge clk);
        tok_valid = 1'b0; hs_ack = 1'b0; hs_timeout = 1'b0;
        fw_txrdy_set = 1'b0; fw_txcmp_clr = 1'b0; fw_rx_clr = 1'b0;
    endtask

    task automatic tok(input logic [1:0] tk, input logic p1, input logic zl,
                       input logic dr, input logic nd, input string tag,
                       input logic [2:0] exp_rsp, input logic exp_zlp);
        apply(OP_TOK, tk, p1, zl, dr, nd);
        check({tag, " rsp"}, {5'd0, rsp_kind}, {5'd0, exp_rsp});
        check({tag, " zlp"}, {7'd0, rsp_zlp}, {7'd0, exp_zlp});
    endtask

    task automatic fw(input logic [2:0] op);
        apply(op, K_SU, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rsp", {5'd0, rsp_kind}, 8'd0);
        check("R1 flags", {2'd0, txrdy, txcmp, rx_setup, rx_out, xfer_dir, irq}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp after release", {5'd0, rsp_kind}, 8'd0);

        // R2 disabled endpoint
        ep_en = 1'b0;
        tok(K_SU, 1'b0, 1'b0, 1'b1, 1'b0, "R2 disabled setup", E_NONE, 1'b0);
        check("R2 rx_setup untouched", {7'd0, rx_setup}, 8'd0);
        check("R2 dir untouched", {7'd0, xfer_dir}, 8'd0);
        ep_en = 1'b1;
        tok(K_IN, 1'b0, 1'b0, 1'b0, 1'b0, "R2 stage stayed idle", E_NAK, 1'b0);

        // control read from the vector table (R3 R5 R6 R7)
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][12:10], VEC[i][9:8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
            check($sformatf("R5 R7 table row %0d rsp", i), {5'd0, rsp_kind}, {5'd0, VEC[i][3:1]});
            check($sformatf("R5 R7 table row %0d zlp", i), {7'd0, rsp_zlp}, {7'd0, VEC[i][0]});
        end
        check("R3 dir latched device-to-host", {7'd0, xfer_dir}, 8'd1);
        check("R6 flags after read", {6'd0, txrdy, txcmp}, 8'd0);

        // R4 no-data transfer
        tok(K_SU, 1'b0, 1'b0, 1'b0, 1'b1, "R3 no-data setup", E_ACK, 1'b0);
        check("R3 dir host-to-device", {7'd0, xfer_dir}, 8'd0);
        check("R3 rx_setup set", {7'd0, rx_setup}, 8'd1);
        fw_irq_en = 1'b1;
        #1 check("R10 irq on rx_setup", {7'd0, irq}, 8'd1);
        tok(K_IN, 1'b0, 1'b0, 1'b0, 1'b0, "R4 status zlp", E_D1, 1'b1);
        fw(OP_TMO);
        check("R4 timeout no txcmp", {7'd0, txcmp}, 8'd0);
        tok(K_IN, 1'b0, 1'b0, 1'b0, 1'b0, "R4 status retry", E_D1, 1'b1);
        fw(OP_ACK);
        check("R4 txcmp after ack", {7'd0, txcmp}, 8'd1);
        tok(K_IN, 1'b0, 1'b0, 1'b0, 1'b0, "R4 idle after status", E_NAK, 1'b0);
        fw_irq_en = 1'b0;
        #1 check("R10 irq masked", {7'd0, irq}, 8'd0);
        fw(OP_CCLR);
        fw(OP_RCLR);
        fw_irq_en = 1'b1;
        #1 check("R10 irq without flags", {7'd0, irq}, 8'd0);
        fw_irq_en = 1'b0;

        // R8 R9 control write
        tok(K_SU, 1'b0, 1'b0, 1'b0, 1'b0, "R3 write setup", E_ACK, 1'b0);
        fw(OP_RCLR);
        tok(K_OUT, 1'b1, 1'b0, 1'b0, 1'b0, "R8 first OUT DATA1", E_ACK, 1'b0);
        check("R8 rx_out set", {7'd0, rx_out}, 8'd1);
        tok(K_OUT, 1'b0, 1'b0, 1'b0, 1'b0, "R8 NAK while full", E_NAK, 1'b0);
        fw(OP_RCLR);
        tok(K_OUT, 1'b1, 1'b0, 1'b0, 1'b0, "R8 duplicate acked", E_ACK, 1'b0);
        check("R8 duplicate dropped", {7'd0, rx_out}, 8'd0);
        tok(K_OUT, 1'b0, 1'b0, 1'b0, 1'b0, "R8 next OUT DATA0", E_ACK, 1'b0);
        check("R8 rx_out set again", {7'd0, rx_out}, 8'd1);
        fw(OP_RCLR);
        tok(K_IN, 1'b0, 1'b0, 1'b0, 1'b0, "R9 status zlp", E_D1, 1'b1);
        fw(OP_TMO);
        tok(K_IN, 1'b0, 1'b0, 1'b0, 1'b0, "R9 status retry", E_D1, 1'b1);
        fw(OP_ACK);
        check("R9 txcmp after ack", {7'd0, txcmp}, 8'd1);
        tok(K_IN, 1'b0, 1'b0, 1'b0, 1'b0, "R9 idle after status", E_NAK, 1'b0);
        fw(OP_CCLR);

        // R6 R11 read, then restart mid-transfer
        tok(K_SU, 1'b0, 1'b0, 1'b1, 1'b0, "R11 read setup", E_ACK, 1'b0);
        fw(OP_RDY);
        check("R6 txrdy loaded", {7'd0, txrdy}, 8'd1);
        tok(K_IN, 1'b0, 1'b0, 1'b0, 1'b0, "R5 data DATA1", E_D1, 1'b0);
        fw(OP_ACK);
        check("R6 ack clears txrdy", {7'd0, txrdy}, 8'd0);
        check("R6 ack sets txcmp", {7'd0, txcmp}, 8'd1);
        fw(OP_RDY);
        tok(K_SU, 1'b0, 1'b0, 1'b1, 1'b0, "R11 restart setup", E_ACK, 1'b0);
        tok(K_IN, 1'b0, 1'b0, 1'b0, 1'b0, "R11 toggle restarted", E_D1, 1'b0);
        fw(OP_ACK);
        tok(K_OUT, 1'b1, 1'b1, 1'b0, 1'b0, "R7 NAK while txcmp", E_NAK, 1'b0);
        fw(OP_CCLR);
        tok(K_OUT, 1'b0, 1'b1, 1'b0, 1'b0, "R7 wrong PID", E_NAK, 1'b0);
        tok(K_OUT, 1'b1, 1'b0, 1'b0, 1'b0, "R7 nonzero length", E_NAK, 1'b0);
        tok(K_OUT, 1'b1, 1'b1, 1'b0, 1'b0, "R7 status accepted", E_ACK, 1'b0);

        // R12 stray handshakes in idle
        fw(OP_RDY);
        fw(OP_ACK);
        check("R12 stray ack keeps txrdy", {7'd0, txrdy}, 8'd1);
        check("R12 stray ack no txcmp", {7'd0, txcmp}, 8'd0);
        fw(OP_TMO);
        check("R12 stray timeout", {6'd0, txrdy, txcmp}, 8'd2);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule